// File: doc/BRIEF.md
# Shifted-Operand Add/Subtract Execution Unit

This unit runs one integer add or subtract per clock. Each operation takes a 32-bit instruction word and the two source values that a register file read on its behalf. The unit decodes the word and shifts the second source by the amount and kind given in the word. When the word asks for a subtract, the shifted value is inverted. The unit then adds both values with a carry-in, at either 32-bit or 64-bit width. The outputs are registered and appear on the clock edge after the word is presented. They carry the result, the destination index, a register write enable, the four condition flags, a flag update enable, and an undefined-instruction indication.

Register index 31 plays two roles. As a source it reads as zero, which gives the negate form when it is the first source. As a destination it discards the write, which gives the compare form, where only the flags are kept. Reserved shift kinds, out-of-range 32-bit shift amounts and words outside this format are all reported as undefined, and nothing is committed for them. A pipeline places the unit between operand read and writeback, and uses the two enables to decide what to commit.

Top module: `addsub_shift_unit`

## Requirements
- R1: The word is decoded as width bit [31] (1 = 64-bit), op [30] (1 = subtract), S [29], fixed pattern [28:24] = 01011, zero bit [21], shift kind [23:22], Rm [20:16], amount [15:10], Rn [9:5], Rd [4:0]. A word whose [28:24] is not 01011, or whose [21] is 1, raises `undef`.
- R2: Shift kind 11 raises `undef`. In 32-bit mode, an amount with bit 5 set also raises `undef`. A 64-bit amount of 32 to 63 is legal.
- R3: While `undef` is high, `regWe` and `flagWe` are low.
- R4: Shift kind 00 is a logical left shift, 01 a logical right shift and 10 an arithmetic right shift that copies the sign bit of the active width. An amount of 0 leaves the operand unchanged.
- R5: For a subtract, the result is Rn-value + NOT(shifted) + 1. For an add, it is Rn-value + shifted. Both are computed at the active width.
- R6: In 32-bit mode, only bits [31:0] of each source are used, and `result[63:32]` is zero.
- R7: `flags` is {N,Z,C,V} in bits [3:0]. N is the top bit of the active-width result, Z is set for a zero result, C is the carry out of the active width (1 = no borrow on a subtract), and V is signed overflow at the active width.
- R8: `flagWe` equals S for a valid, defined word.
- R9: An Rn or Rm index of 31 makes that source read as zero, whatever its input value.
- R10: An Rd index of 31 holds `regWe` low, and the flags and `flagWe` still follow S.
- R11: Outputs follow the word by one clock. `outValid` repeats `inValid` one cycle later, and while it is low, `regWe`, `flagWe` and `undef` are low.
- R12: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Word and sources are present this cycle |
| instrWord | input | 32 | Instruction word |
| srcA | input | 64 | Value read for Rn |
| srcB | input | 64 | Value read for Rm |
| outValid | output | 1 | Registered outputs carry an operation |
| result | output | 64 | Sum, zero-extended in 32-bit mode |
| destIdx | output | 5 | Rd index of the operation |
| regWe | output | 1 | Commit result to Rd |
| flags | output | 4 | {N,Z,C,V} |
| flagWe | output | 1 | Commit flags |
| undef | output | 1 | Word is undefined |

## Verification
The unit holds no state other than its output register, so a wrong internal value shows at the ports on the very next clock edge. A wrong shift kind, a wrong mask of the 32-bit lane or a wrong carry polarity changes `result` or `flags` in that same output cycle. A decode slip shows as a wrong `undef` or a wrong enable in that cycle. The stimulus is compared with an independent arithmetic model, and it covers every shift kind at amounts 0, 1 and the width maximum, signed overflow, borrow, and the register-31 forms.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int SHAMT_W = 6;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_RSV = 2'b11
  } shift_e;

  // strobes from decode to the datapath
  typedef struct packed {
    logic                is64;
    logic                subOp;
    shift_e              shiftKind;
    logic [SHAMT_W-1:0]  shiftAmt;
    logic                zeroA;
    logic                zeroB;
  } dpCtrl_t;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 5
) (
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  output dpCtrl_t            strobes,
  output logic               undefNext,
  output logic               regWeNext,
  output logic               flagWeNext,
  output logic [IDX_W-1:0]   rdIdx
);
  localparam int POS_WIDE = 31;
  localparam int POS_OP   = 30;
  localparam int POS_S    = 29;
  localparam int FIX_LO   = 24;
  localparam int FIX_W    = 5;
  localparam logic [FIX_W-1:0] FIX_VAL = 5'b01011;
  localparam int SH_LO    = 22;
  localparam int POS_ZERO = 21;
  localparam int RM_LO    = 16;
  localparam int AMT_LO   = 10;
  localparam int RN_LO    = 5;
  localparam int RD_LO    = 0;
  localparam logic [IDX_W-1:0] ZERO_IDX = {IDX_W{1'b1}};

  logic               isWide;
  logic [1:0]         shField;
  logic [SHAMT_W-1:0] amtField;
  logic [IDX_W-1:0]   rnIdx;
  logic [IDX_W-1:0]   rmIdx;
  logic               undefDet;

  always_comb begin
    isWide   = instrWord[POS_WIDE];
    shField  = instrWord[SH_LO +: 2];
    amtField = instrWord[AMT_LO +: SHAMT_W];
    rnIdx    = instrWord[RN_LO +: IDX_W];
    rmIdx    = instrWord[RM_LO +: IDX_W];
    rdIdx    = instrWord[RD_LO +: IDX_W];

    undefDet = (instrWord[FIX_LO +: FIX_W] != FIX_VAL)
             | instrWord[POS_ZERO]
             | (shift_e'(shField) == SH_RSV)
             | (!isWide & amtField[SHAMT_W-1]);

    strobes.is64      = isWide;
    strobes.subOp     = instrWord[POS_OP];
    strobes.shiftKind = shift_e'(shField);
    strobes.shiftAmt  = amtField;
    strobes.zeroA     = (rnIdx == ZERO_IDX);
    strobes.zeroB     = (rmIdx == ZERO_IDX);

    undefNext  = inValid & undefDet;
    regWeNext  = inValid & !undefDet & (rdIdx != ZERO_IDX);
    flagWeNext = inValid & !undefDet & instrWord[POS_S];
  end
endmodule

// File: rtl/addsub_dp.sv
module addsub_dp
  import addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  dpCtrl_t           strobes,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] sumOut,
  output logic [3:0]        nzcvOut
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic [DATA_W-1:0] laneRes   [LANES];
  logic [3:0]        laneFlags [LANES];

  // lane 0 works at half width, lane 1 at full width
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam int W     = (L == 0) ? HALF_W : DATA_W;
    localparam int AMT_W = $clog2(W);

    logic [W-1:0]     opA;
    logic [W-1:0]     opB;
    logic [W-1:0]     shifted;
    logic [W-1:0]     addend;
    logic [AMT_W-1:0] amt;
    logic [W:0]       sumW;
    logic             ovf;

    always_comb begin
      opA = strobes.zeroA ? '0 : srcA[W-1:0];
      opB = strobes.zeroB ? '0 : srcB[W-1:0];
      amt = strobes.shiftAmt[AMT_W-1:0];
      case (strobes.shiftKind)
        SH_LSL:  shifted = opB << amt;
        SH_LSR:  shifted = opB >> amt;
        SH_ASR:  shifted = W'($signed(opB) >>> amt);
        default: shifted = '0;
      endcase
      addend = strobes.subOp ? ~shifted : shifted;
      sumW   = (W+1)'(opA) + (W+1)'(addend) + (W+1)'(strobes.subOp);
      ovf    = (opA[W-1] == addend[W-1]) && (sumW[W-1] != opA[W-1]);
    end

    assign laneRes[L]   = DATA_W'(sumW[W-1:0]);
    assign laneFlags[L] = {sumW[W-1], (sumW[W-1:0] == '0), sumW[W], ovf};
  end

  always_comb begin
    sumOut  = strobes.is64 ? laneRes[1]   : laneRes[0];
    nzcvOut = strobes.is64 ? laneFlags[1] : laneFlags[0];
  end
endmodule

// File: rtl/addsub_shift_unit.sv
module addsub_shift_unit
  import addsub_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  output logic               outValid,
  output logic [DATA_W-1:0]  result,
  output logic [IDX_W-1:0]   destIdx,
  output logic               regWe,
  output logic [3:0]         flags,
  output logic               flagWe,
  output logic               undef
);
  localparam int HALF_W = DATA_W / 2;

  dpCtrl_t           strobes;
  logic              undefNext;
  logic              regWeNext;
  logic              flagWeNext;
  logic [IDX_W-1:0]  rdIdx;
  logic [DATA_W-1:0] sumNext;
  logic [3:0]        nzcvNext;

  addsub_ctrl #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_ctrl (
    .inValid    (inValid),
    .instrWord  (instrWord),
    .strobes    (strobes),
    .undefNext  (undefNext),
    .regWeNext  (regWeNext),
    .flagWeNext (flagWeNext),
    .rdIdx      (rdIdx)
  );

  addsub_dp #(.DATA_W(DATA_W)) u_dp (
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .sumOut  (sumNext),
    .nzcvOut (nzcvNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      destIdx  <= '0;
      regWe    <= 1'b0;
      flags    <= '0;
      flagWe   <= 1'b0;
      undef    <= 1'b0;
    end else begin
      outValid <= inValid;
      result   <= sumNext;
      destIdx  <= rdIdx;
      regWe    <= regWeNext;
      flags    <= nzcvNext;
      flagWe   <= flagWeNext;
      undef    <= undefNext;
    end
  end

  // R3: an undefined word commits nothing
  p_undef_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    undef |-> (!regWe && !flagWe));

  // R10: destination 31 never writes
  p_rd31_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (destIdx != {IDX_W{1'b1}}));

  // R6: half-width results are zero-extended
  p_half_zero_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !instrWord[INSTR_W-1]) |=> (result[DATA_W-1:HALF_W] == '0));

  // R7: Z agrees with the registered result
  p_z_matches_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !undef) |-> (flags[2] == (result == '0)));

  // R11: one-cycle valid pipe, enables quiet when idle
  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!regWe && !flagWe && !undef));

  // R8: flag enable follows S of a defined word
  p_flagwe_s_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !undefNext) |=> (flagWe == $past(instrWord[29])));
endmodule

// File: tb/sim_addsub_shift_unit.sv
module sim_addsub_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic [63:0] result;
  logic [4:0]  destIdx;
  logic        regWe;
  logic [3:0]  flags;
  logic        flagWe;
  logic        undef;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  addsub_shift_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result),
    .destIdx(destIdx), .regWe(regWe), .flags(flags), .flagWe(flagWe),
    .undef(undef)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        bad;
    logic [63:0] res;
    logic [3:0]  nzcv;
    logic        we;
    logic        fwe;
    logic [4:0]  rd;
  } expect_t;

  function automatic logic [31:0] enc(input logic sf, input logic op, input logic s,
      input logic [1:0] sh, input logic [4:0] rm, input logic [5:0] amt,
      input logic [4:0] rn, input logic [4:0] rd);
    return {sf, op, s, 5'b01011, sh, 1'b0, rm, amt, rn, rd};
  endfunction

  function automatic expect_t model(input logic [31:0] w, input logic [63:0] a,
                                    input logic [63:0] b);
    expect_t e;
    logic sf, op, s;
    logic [1:0] sh;
    logic [5:0] amt;
    logic [63:0] va, vb, t;
    logic [64:0] wide;
    logic [32:0] narrow;
    sf = w[31]; op = w[30]; s = w[29]; sh = w[23:22]; amt = w[15:10];
    e.rd  = w[4:0];
    e.bad = (w[28:24] != 5'b01011) || w[21] || (sh == 2'b11) || (!sf && amt[5]);
    va = (w[9:5] == 5'd31) ? 64'd0 : a;
    vb = (w[20:16] == 5'd31) ? 64'd0 : b;
    if (sf) begin
      if (sh == 2'b00)      t = vb << amt;
      else if (sh == 2'b01) t = vb >> amt;
      else                  t = $signed(vb) >>> amt;
      if (op) t = ~t;
      wide = {1'b0, va} + {1'b0, t} + {64'd0, op};
      e.res = wide[63:0];
      e.nzcv = {wide[63], wide[63:0] == 64'd0, wide[64],
                (va[63] == t[63]) && (wide[63] != va[63])};
    end else begin
      logic [31:0] ta;
      logic [31:0] tb;
      ta = va[31:0];
      if (sh == 2'b00)      tb = vb[31:0] << amt[4:0];
      else if (sh == 2'b01) tb = vb[31:0] >> amt[4:0];
      else                  tb = $signed(vb[31:0]) >>> amt[4:0];
      if (op) tb = ~tb;
      narrow = {1'b0, ta} + {1'b0, tb} + {32'd0, op};
      e.res = {32'd0, narrow[31:0]};
      e.nzcv = {narrow[31], narrow[31:0] == 32'd0, narrow[32],
                (ta[31] == tb[31]) && (narrow[31] != ta[31])};
    end
    e.we  = !e.bad && (e.rd != 5'd31);
    e.fwe = !e.bad && s;
    return e;
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runOne(input string req, input logic [31:0] w,
                        input logic [63:0] a, input logic [63:0] b);
    expect_t e;
    e = model(w, a, b);
    @(negedge clk);
    inValid = 1'b1; instrWord = w; srcA = a; srcB = b;
    @(negedge clk);
    inValid = 1'b0;
    checkVal(req, "outValid", 64'(outValid), 64'd1);
    checkVal(req, "undef", 64'(undef), 64'(e.bad));
    checkVal(req, "regWe", 64'(regWe), 64'(e.we));
    checkVal(req, "flagWe", 64'(flagWe), 64'(e.fwe));
    if (!e.bad) begin
      checkVal(req, "result", result, e.res);
      checkVal(req, "flags", 64'(flags), 64'(e.nzcv));
      checkVal(req, "destIdx", 64'(destIdx), 64'(e.rd));
    end
  endtask

  task automatic t_reset;
    checkVal("R12", "outValid", 64'(outValid), 64'd0);
    checkVal("R12", "result", result, 64'd0);
    checkVal("R12", "enables", 64'({regWe, flagWe, undef}), 64'd0);
    checkVal("R12", "flags", 64'(flags), 64'd0);
    checkVal("R12", "destIdx", 64'(destIdx), 64'd0);
  endtask

  task automatic t_add_sub;
    runOne("R5", enc(1, 0, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3), 64'd5, 64'd7);
    checkVal("R5", "sum", result, 64'd12);
    runOne("R5", enc(1, 1, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3), 64'd3, 64'd5);
    checkVal("R7", "borrow N..V", 64'(flags), 64'b1000);
    runOne("R7", enc(1, 1, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3), 64'd9, 64'd9);
    checkVal("R7", "equal N..V", 64'(flags), 64'b0110);
    runOne("R7", enc(1, 0, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3),
           64'h7fff_ffff_ffff_ffff, 64'd1);
    checkVal("R7", "add ovf", 64'(flags), 64'b1001);
  endtask

  task automatic t_half_width;
    runOne("R6", enc(0, 1, 1, 2'b00, 5'd4, 6'd0, 5'd5, 5'd6),
           64'hdead_beef_7fff_ffff, 64'hffff_0000_ffff_ffff);
    checkVal("R6", "upper zero", result[63:32], 64'd0);
    checkVal("R7", "sub ovf 32", 64'(flags), 64'b1001);
    runOne("R6", enc(0, 0, 1, 2'b00, 5'd4, 6'd0, 5'd5, 5'd6),
           64'h1_ffff_ffff, 64'd1);
    checkVal("R7", "carry 32", 64'(flags), 64'b0110);
  endtask

  task automatic t_shifts;
    for (int k = 0; k < 3; k++) begin
      runOne("R4", enc(1, 0, 1, 2'(k), 5'd8, 6'd0,  5'd9, 5'd10), 64'd1, 64'h8000_0000_0000_00f0);
      runOne("R4", enc(1, 0, 1, 2'(k), 5'd8, 6'd1,  5'd9, 5'd10), 64'd1, 64'h8000_0000_0000_00f0);
      runOne("R4", enc(1, 0, 1, 2'(k), 5'd8, 6'd63, 5'd9, 5'd10), 64'd1, 64'h8000_0000_0000_00f1);
      runOne("R4", enc(1, 1, 1, 2'(k), 5'd8, 6'd36, 5'd9, 5'd10), 64'd0, 64'hf000_0000_8000_0000);
      runOne("R4", enc(0, 0, 1, 2'(k), 5'd8, 6'd31, 5'd9, 5'd10), 64'd0, 64'h0000_0001_8000_0001);
      runOne("R4", enc(0, 1, 1, 2'(k), 5'd8, 6'd4,  5'd9, 5'd10), 64'd0, 64'h0000_0000_8000_0010);
    end
    runOne("R4", enc(0, 0, 0, 2'b10, 5'd8, 6'd4, 5'd9, 5'd10), 64'd0, 64'h0000_0000_8000_0000);
    checkVal("R4", "asr32 sign", result, 64'h0000_0000_f800_0000);
  endtask

  task automatic t_reg31;
    runOne("R10", enc(1, 1, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd31), 64'd4, 64'd4);
    checkVal("R10", "no write", 64'(regWe), 64'd0);
    checkVal("R10", "flags kept", 64'({flagWe, flags}), 64'b1_0110);
    runOne("R9", enc(1, 1, 1, 2'b00, 5'd2, 6'd0, 5'd31, 5'd7), 64'd99, 64'd5);
    checkVal("R9", "negate", result, 64'hffff_ffff_ffff_fffb);
    runOne("R9", enc(0, 0, 1, 2'b00, 5'd31, 6'd0, 5'd1, 5'd7), 64'd5, 64'd77);
    checkVal("R9", "rm zero", result, 64'd5);
  endtask

  task automatic t_no_flags;
    runOne("R8", enc(1, 1, 0, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3), 64'd1, 64'd1);
    checkVal("R8", "flagWe low", 64'(flagWe), 64'd0);
    checkVal("R8", "regWe high", 64'(regWe), 64'd1);
  endtask

  task automatic t_undef;
    runOne("R2", enc(1, 1, 1, 2'b11, 5'd2, 6'd0, 5'd1, 5'd3), 64'd1, 64'd1);
    checkVal("R2", "rsv shift", 64'({undef, regWe, flagWe}), 64'b100);
    runOne("R2", enc(0, 1, 1, 2'b00, 5'd2, 6'd32, 5'd1, 5'd3), 64'd1, 64'd1);
    checkVal("R3", "amt32 half", 64'({undef, regWe, flagWe}), 64'b100);
    runOne("R2", enc(1, 1, 1, 2'b00, 5'd2, 6'd32, 5'd1, 5'd3), 64'd1, 64'h1_0000_0000);
    checkVal("R2", "amt32 wide ok", 64'(undef), 64'd0);
    runOne("R1", enc(1, 1, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3) ^ 32'h0100_0000, 64'd1, 64'd1);
    checkVal("R1", "bad pattern", 64'({undef, regWe, flagWe}), 64'b100);
    runOne("R1", enc(1, 1, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3) | 32'h0020_0000, 64'd1, 64'd1);
    checkVal("R1", "bit21 set", 64'(undef), 64'd1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    inValid = 1'b0; instrWord = enc(1, 1, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3);
    @(negedge clk);
    checkVal("R11", "idle valid", 64'(outValid), 64'd0);
    checkVal("R11", "idle enables", 64'({regWe, flagWe, undef}), 64'd0);
  endtask

  task automatic t_sweep;
    logic [63:0] lfsr;
    lfsr = 64'h1234_5678_9abc_def1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      logic [63:0] a;
      logic [63:0] b;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      a = lfsr ^ {lfsr[31:0], lfsr[63:32]};
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      b = lfsr * 64'd2862933555777941757;
      w = enc(lfsr[3], lfsr[7], lfsr[11], lfsr[14:13] % 2'd3, lfsr[20:16],
              lfsr[3] ? lfsr[29:24] : {1'b0, lfsr[28:24]}, lfsr[36:32], lfsr[44:40]);
      runOne("R5", w, a, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_add_sub();
    t_half_width();
    t_shifts();
    t_reg31();
    t_no_flags();
    t_undef();
    t_idle();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule